// File: doc/BRIEF.md
# Receive Sample Channel Packer

This block sits between a bank of up to four receive downconverter channels and a host transfer FIFO. Each downconverter channel supplies a complex sample: a 16-bit in-phase value and a 16-bit quadrature value. When the sample strobe fires, the block captures every channel at once. It then sends the values out as a serial stream of 16-bit words, one value per clock. While it does so, the downconverters are free to move on to their next sample.

Two configuration inputs set the stream shape. A channel-count input selects how many channels are active. A format word gives a right-shift amount, an output width, a flag that selects whether quadrature values are included, and a half-band bypass flag that this block does not use. In 16-bit mode each value becomes one output word. In 8-bit mode each value is arithmetically shifted right by eight and narrowed to a byte, and two bytes are packed into each output word. The configuration is sampled together with the samples, at the strobe. A synchronous clear drops any stream in progress and any byte that is waiting for its partner.

Top module: `rx_chan_packer`

## Requirements
- R1: `cfg_nch` is read as an unsigned count. The code 2 selects two channels and the code 4 selects four. Every other code, 1 included, selects one channel. With quadrature enabled, a sample period therefore yields 2, 4 or 8 values.
- R2: With quadrature enabled, the values of one period leave in this order: channel 0 in-phase, channel 0 quadrature, channel 1 in-phase, channel 1 quadrature, and so on up to the last active channel. Channel k occupies bits 16k+15:16k of `smp_i` and `smp_q`.
- R3: When `cfg_fmt` bit 9 is 0, only the in-phase values are delivered, in the order channel 0, channel 1, and so on. When the bit is 1, both values of each channel are delivered.
- R4: The fields of `cfg_fmt` are: shift amount in bits 3:0, output width in bits 8:4, quadrature enable in bit 9, and half-band bypass in bit 10. Bit 10 has no effect on the output.
- R5: With width 16 and shift 0, each value appears unchanged as one `word_o` word, with `word_vld` high for one cycle.
- R6: With width 8 and shift 8, each value is arithmetically shifted right by 8 and its low byte is kept, which equals the value's bits 15:8. The first byte of a pair goes in `word_o[7:0]` and the second in `word_o[15:8]`. A word is emitted only when both bytes are present.
- R7: In 8-bit mode, a byte left unpaired at the end of a sample period stays held. It is paired with the first byte of the next period.
- R8: Any width and shift combination other than 16/0 and 8/8 behaves exactly like width 16 with shift 0.
- R9: When `clear` is high at a clock edge, the period in progress is abandoned and any held byte is discarded. `word_vld` is low in the following cycle, and no further word appears until the next strobe.
- R10: The channel samples, `cfg_nch` and `cfg_fmt` are sampled at the clock edge where `smp_stb` is high. Changes to these inputs during the rest of that period do not alter its output.
- R11: While reset is applied, and until the first strobe after it, `word_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| clear | input | 1 | Synchronous clear of the stream position and any held byte |
| smp_stb | input | 1 | One-cycle strobe: a new sample is present on all channels |
| smp_i | input | 64 | In-phase samples, channel k in bits 16k+15:16k |
| smp_q | input | 64 | Quadrature samples, channel k in bits 16k+15:16k |
| cfg_nch | input | 3 | Active channel count code |
| cfg_fmt | input | 11 | Format word: shift, width, quadrature enable, bypass |
| word_o | output | 16 | Output word to the host FIFO |
| word_vld | output | 1 | `word_o` carries a valid word this cycle |

## Verification
The assertions assume that `smp_stb` never rises while a period is still being sent out. This means strobes are spaced at least one value-count of cycles apart. They also assume that the width mode is not switched while a byte is held. The stimulus meets both assumptions. It waits ten cycles after every strobe, which is more than the longest period of eight values. Every 8-bit run either leaves no byte held or is followed by a clear before the mode changes. After each strobe, the bench scrambles the sample and configuration inputs, so any leak of a late change into the output stream is exposed.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  // Output word format after decode of the width and shift fields
  typedef enum logic {
    FMT_W16 = 1'b0,
    FMT_W8  = 1'b1
  } rxp_fmt_e;

  // Bit positions inside the format word
  localparam int FMT_SHIFT_LSB = 0;
  localparam int FMT_WIDTH_LSB = 4;
  localparam int FMT_WANTQ_BIT = 9;

endpackage

// File: rtl/rxp_cfg_decode.sv
module rxp_cfg_decode
  import rxp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 4
) (
  input  logic [2:0]       nch_code,
  input  logic [10:0]      fmt_word,
  output logic [CNT_W-1:0] total_vals,
  output logic             want_q,
  output rxp_fmt_e         fmt_mode
);

  logic [CNT_W-1:0] ch_cnt;
  logic [3:0]       shift_f;
  logic [4:0]       width_f;

  assign shift_f = fmt_word[FMT_SHIFT_LSB +: 4];
  assign width_f = fmt_word[FMT_WIDTH_LSB +: 5];
  assign want_q  = fmt_word[FMT_WANTQ_BIT];

  // Legal counts are 2 and 4 (if present); every other code means one channel
  always_comb begin
    ch_cnt = CNT_W'(1);
    if (nch_code == 3'd2 && NUM_CH >= 2) ch_cnt = CNT_W'(2);
    if (nch_code == 3'd4 && NUM_CH >= 4) ch_cnt = CNT_W'(4);
  end

  assign total_vals = want_q ? (ch_cnt << 1) : ch_cnt;

  // Only 8/8 selects byte mode; anything unsupported falls back to 16/0
  always_comb begin
    fmt_mode = FMT_W16;
    if (width_f == 5'd8 && shift_f == 4'd8) fmt_mode = FMT_W8;
  end

endmodule

// File: rtl/rxp_sequencer.sv
module rxp_sequencer
  import rxp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SMP_W  = 16,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    stb,
  input  logic [NUM_CH*SMP_W-1:0] i_bus,
  input  logic [NUM_CH*SMP_W-1:0] q_bus,
  input  logic [CNT_W-1:0]        total_in,
  input  logic                    want_q_in,
  input  rxp_fmt_e                mode_in,
  output logic [SMP_W-1:0]        val,
  output logic                    val_vld,
  output rxp_fmt_e                mode_out
);

  logic [NUM_CH*SMP_W-1:0] cap_i_q, cap_i_d;
  logic [NUM_CH*SMP_W-1:0] cap_q_q, cap_q_d;
  logic [CNT_W-1:0]        total_q, total_d;
  logic                    wantq_q, wantq_d;
  rxp_fmt_e                mode_q, mode_d;
  logic                    busy_q, busy_d;
  logic [CNT_W-1:0]        idx_q, idx_d;
  logic                    load_en;

  logic [SMP_W-1:0] lane_i [NUM_CH];
  logic [SMP_W-1:0] lane_q [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lane
      assign lane_i[g] = cap_i_q[g*SMP_W +: SMP_W];
      assign lane_q[g] = cap_q_q[g*SMP_W +: SMP_W];
    end
  endgenerate

  assign load_en = stb && !clear;

  // Next-state logic
  always_comb begin
    cap_i_d = cap_i_q;
    cap_q_d = cap_q_q;
    total_d = total_q;
    wantq_d = wantq_q;
    mode_d  = mode_q;
    busy_d  = busy_q;
    idx_d   = idx_q;
    if (clear) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (load_en) begin
      cap_i_d = i_bus;
      cap_q_d = q_bus;
      total_d = total_in;
      wantq_d = want_q_in;
      mode_d  = mode_in;
      busy_d  = 1'b1;
      idx_d   = '0;
    end else if (busy_q) begin
      if (idx_q == total_q - CNT_W'(1)) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + CNT_W'(1);
      end
    end
  end

  // Capture registers: clock-enabled, no reset needed on data
  always_ff @(posedge clk) begin
    if (load_en) begin
      cap_i_q <= cap_i_d;
      cap_q_q <= cap_q_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= CNT_W'(1);
      wantq_q <= 1'b0;
      mode_q  <= FMT_W16;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      total_q <= total_d;
      wantq_q <= wantq_d;
      mode_q  <= mode_d;
      busy_q  <= busy_d;
      idx_q   <= idx_d;
    end
  end

  // Value select: interleave I/Q when quadrature is wanted
  logic [CNT_W-1:0] ch_sel;
  logic             is_q;

  assign ch_sel   = wantq_q ? (idx_q >> 1) : idx_q;
  assign is_q     = wantq_q && idx_q[0];
  assign val      = is_q ? lane_q[ch_sel[$clog2(NUM_CH)-1:0]]
                         : lane_i[ch_sel[$clog2(NUM_CH)-1:0]];
  assign val_vld  = busy_q;
  assign mode_out = mode_q;

  // Input assumption: no new strobe while a period is still streaming
  assert_stb_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !clear |-> !stb);

  // A strobe starts a period at its first value
  assert_start_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb && !clear |=> val_vld && idx_q == '0);

  // The position never runs past the configured value count
  assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q < total_q);

  // Clear stops the stream
  assert_clear_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !val_vld);

endmodule

// File: rtl/rxp_pack.sv
module rxp_pack
  import rxp_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [SMP_W-1:0] in_val,
  input  logic             in_vld,
  input  rxp_fmt_e         mode,
  output logic [SMP_W-1:0] word,
  output logic             word_vld
);

  localparam int NARROW_W = SMP_W / 2;

  logic [NARROW_W-1:0] lo_q, lo_d;
  logic                half_q, half_d;
  logic [SMP_W-1:0]    word_q, word_d;
  logic                vld_q, vld_d;
  logic [SMP_W-1:0]    shifted;
  logic [NARROW_W-1:0] narrow;

  assign shifted = SMP_W'($signed(in_val) >>> NARROW_W);
  assign narrow  = shifted[NARROW_W-1:0];

  always_comb begin
    lo_d   = lo_q;
    half_d = half_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (clear) begin
      half_d = 1'b0;
    end else if (in_vld) begin
      if (mode == FMT_W16) begin
        word_d = in_val;
        vld_d  = 1'b1;
      end else if (!half_q) begin
        lo_d   = narrow;
        half_d = 1'b1;
      end else begin
        word_d = {narrow, lo_q};
        vld_d  = 1'b1;
        half_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld && !clear) begin
      lo_q   <= lo_d;
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      vld_q  <= vld_d;
    end
  end

  assign word     = word_q;
  assign word_vld = vld_q;

  assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !word_vld);

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !clear && mode == FMT_W16 |=> word_vld && word == $past(in_val));

  assert_first_byte_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !clear && mode == FMT_W8 && !half_q |=> !word_vld);

  assert_pair_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !clear && mode == FMT_W8 && half_q |=> word_vld);

  // Input assumption: no switch to 16-bit mode while a byte is held
  assert_no_mode_mix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_q && in_vld |-> mode == FMT_W8);

endmodule

// File: rtl/rx_chan_packer.sv
module rx_chan_packer
  import rxp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SMP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    smp_stb,
  input  logic [NUM_CH*SMP_W-1:0] smp_i,
  input  logic [NUM_CH*SMP_W-1:0] smp_q,
  input  logic [2:0]              cfg_nch,
  input  logic [10:0]             cfg_fmt,
  output logic [SMP_W-1:0]        word_o,
  output logic                    word_vld
);

  localparam int CNT_W = $clog2(2*NUM_CH + 1);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [CNT_W-1:0] dec_total;
  logic             dec_wantq;
  rxp_fmt_e         dec_mode;
  logic [SMP_W-1:0] seq_val;
  logic             seq_vld;
  rxp_fmt_e         seq_mode;

  rxp_cfg_decode #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dec (
    .nch_code   (cfg_nch),
    .fmt_word   (cfg_fmt),
    .total_vals (dec_total),
    .want_q     (dec_wantq),
    .fmt_mode   (dec_mode)
  );

  rxp_sequencer #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .clear     (clear),
    .stb       (smp_stb),
    .i_bus     (smp_i),
    .q_bus     (smp_q),
    .total_in  (dec_total),
    .want_q_in (dec_wantq),
    .mode_in   (dec_mode),
    .val       (seq_val),
    .val_vld   (seq_vld),
    .mode_out  (seq_mode)
  );

  rxp_pack #(.SMP_W(SMP_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clear    (clear),
    .in_val   (seq_val),
    .in_vld   (seq_vld),
    .mode     (seq_mode),
    .word     (word_o),
    .word_vld (word_vld)
  );

  // No word can appear without a value having entered the packer
  assert_word_has_source_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    word_vld |-> $past(seq_vld));

endmodule

// File: tb/rx_chan_packer_tb.sv
`timescale 1ns/1ps
module rx_chan_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear;
  logic        smp_stb;
  logic [63:0] smp_i, smp_q;
  logic [2:0]  cfg_nch;
  logic [10:0] cfg_fmt;
  logic [15:0] word_o;
  logic        word_vld;

  always #2 clk = ~clk;  // 250 MHz

  rx_chan_packer dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .smp_stb(smp_stb),
    .smp_i(smp_i), .smp_q(smp_q), .cfg_nch(cfg_nch), .cfg_fmt(cfg_fmt),
    .word_o(word_o), .word_vld(word_vld)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  // Bench model of the held byte
  bit        bm_half = 0;
  logic [7:0] bm_lo;

  function automatic logic [10:0] fmt(input int width, input int shift,
                                      input bit wq, input bit byp);
    return {byp, wq, 5'(width), 4'(shift)};
  endfunction

  // Monitor: pop and compare every produced word
  always @(negedge clk) begin
    if (rst_n && word_vld && !done) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL unexpected word: got %h expected none", word_o);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (word_o !== e) begin
          n_errors++;
          $display("FAIL %s: got %h expected %h", t, word_o, e);
        end
      end
    end
  end

  task automatic push(input logic [15:0] w, input string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  // Driver: compute expectations from the requirements, then strobe
  task automatic send_period(input logic [2:0] nch, input logic [10:0] f,
                             input logic [63:0] iv, input logic [63:0] qv,
                             input string t);
    int  n;
    bit  wq, w8;
    n  = (nch == 3'd2) ? 2 : (nch == 3'd4) ? 4 : 1;       // R1
    wq = f[9];                                            // R3
    w8 = (f[8:4] == 5'd8) && (f[3:0] == 4'd8);            // R6, R8
    for (int c = 0; c < n; c++) begin
      for (int p = 0; p < (wq ? 2 : 1); p++) begin         // R2 order
        logic [15:0] s;
        s = p ? qv[c*16 +: 16] : iv[c*16 +: 16];
        if (!w8) push(s, t);
        else if (!bm_half) begin bm_lo = s[15:8]; bm_half = 1; end
        else begin push({s[15:8], bm_lo}, t); bm_half = 0; end
      end
    end
    @(negedge clk);
    cfg_nch = nch; cfg_fmt = f; smp_i = iv; smp_q = qv; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    // R10: scramble every captured input after the strobe
    smp_i = {$urandom, $urandom}; smp_q = {$urandom, $urandom};
    cfg_nch = 3'($urandom); cfg_fmt = 11'($urandom);
    repeat (10) @(negedge clk);
  endtask

  task automatic expect_drained(input string t);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL %s: got %0d pending words expected 0", t, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    bm_half = 0;
  endtask

  localparam logic [63:0] IA = 64'h4444_3333_2222_1111;
  localparam logic [63:0] QA = 64'hDDDD_CCCC_BBBB_AAAA;
  localparam logic [63:0] IB = 64'h80F1_7F02_C3A4_1B55;
  localparam logic [63:0] QB = 64'hFE60_0177_9A88_E599;

  initial begin
    rst_n = 1'b0; clear = 1'b0; smp_stb = 1'b0;
    smp_i = '0; smp_q = '0; cfg_nch = 3'd1; cfg_fmt = '0;
    repeat (3) @(negedge clk);
    n_checks++;  // R11 reset state
    if (word_vld !== 1'b0) begin
      n_errors++; $display("FAIL R11: got %b expected 0", word_vld);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    n_checks++;  // R11 idle after reset
    if (word_vld !== 1'b0) begin
      n_errors++; $display("FAIL R11 idle: got %b expected 0", word_vld);
    end

    send_period(3'd4, fmt(16, 0, 1, 0), IA, QA, "R2 four channels IQ");
    expect_drained("R1 four channels");
    send_period(3'd2, fmt(16, 0, 1, 0), IB, QB, "R1 two channels IQ");
    expect_drained("R1 two channels");
    send_period(3'd1, fmt(16, 0, 1, 0), IA, QB, "R5 one channel IQ");
    expect_drained("R5 one channel");
    send_period(3'd4, fmt(16, 0, 0, 0), IB, QA, "R3 I only four");
    expect_drained("R3 I only");
    send_period(3'd3, fmt(16, 0, 1, 0), IA, QA, "R1 code 3 as one");
    send_period(3'd0, fmt(16, 0, 0, 0), IB, QB, "R1 code 0 as one");
    expect_drained("R1 illegal codes");
    send_period(3'd2, fmt(16, 0, 1, 1), IA, QB, "R4 bypass ignored");
    expect_drained("R4 bypass");

    // 8-bit packing
    send_period(3'd2, fmt(8, 8, 1, 0), IB, QB, "R6 byte pack two ch");
    expect_drained("R6 byte pack");
    send_period(3'd4, fmt(8, 8, 0, 1), IB, QA, "R6 byte pack I only");
    expect_drained("R6 I only");
    // R7: odd count per period carries a byte across periods
    send_period(3'd1, fmt(8, 8, 0, 0), IB, QB, "R7 first half");
    expect_drained("R7 held byte");
    send_period(3'd1, fmt(8, 8, 0, 0), QB, IB, "R7 pair across periods");
    expect_drained("R7 paired");

    // R8 unsupported combos fall back to pass-through
    send_period(3'd2, fmt(8, 0, 1, 0), IB, QB, "R8 width8 shift0");
    send_period(3'd1, fmt(12, 4, 1, 0), QB, IA, "R8 width12 shift4");
    expect_drained("R8 fallback");

    // R9: held byte is discarded by clear
    send_period(3'd1, fmt(8, 8, 0, 0), 64'h0000_0000_0000_AB00, QA, "R9 pre-clear");
    pulse_clear();
    send_period(3'd1, fmt(8, 8, 0, 0), 64'h0000_0000_0000_1200, QA, "R9 after clear");
    send_period(3'd1, fmt(8, 8, 0, 0), 64'h0000_0000_0000_3400, QA, "R9 after clear");
    expect_drained("R9 byte dropped");

    // R9: clear in the middle of a period
    push(16'h1111, "R9 mid clear v0");
    push(16'hAAAA, "R9 mid clear v1");
    @(negedge clk);
    cfg_nch = 3'd4; cfg_fmt = fmt(16, 0, 1, 0); smp_i = IA; smp_q = QA; smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    repeat (10) @(negedge clk);
    expect_drained("R9 mid clear");

    // R10: strobe with one config, then change it at once
    send_period(3'd4, fmt(16, 0, 1, 0), QA, IA, "R10 late change ignored");
    expect_drained("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule